// File: doc/BRIEF.md
# Prefetch Unit with Branch Folding

This block is the front of a 32-bit load/store core's pipeline. It fetches instruction words from a simple memory port into a three-entry prefetch queue. It watches the head of that queue for conditional relative branches and predicts each branch from the sign of its offset alone. It then removes the branch from the stream, so that the instruction predicted to follow is issued in the branch's place.

Each issued instruction carries its PC and an effective 4-bit condition. A folded instruction also carries a side tag with three fields: the branch PC, the predicted direction, and the address of the path that was not chosen. The execute stage evaluates the effective condition to settle the branch. It hands the not-chosen address back on the resolve port. When it signals a mispredict, the unit flushes its queue and any fetch in flight, then restarts fetching at that address.

Top module: `prefetch_fold_unit`

## Requirements
- R1: While reset is held, `iss_valid` is low. In the first cycle after reset is released, `imem_req` is high with `imem_addr` equal to the reset PC (0 by default).
- R2: A word that is not a branch is issued in program order with its own PC. `iss_cond` equals `iss_instr[31:28]`, and both `iss_folded` and `iss_tag_vld` are 0.
- R3: A word is a branch only when bits [27:25] are 3'b101. Its target is PC + 8 + (bits [23:0] sign-extended and shifted left by 2). A word whose bits [27:25] hold any other value, such as 3'b100, is issued as a plain instruction.
- R4: A branch is predicted not taken when its condition is not 4'b1110 and offset bit 23 is 0. If the next word is not a branch, the branch itself is never issued. The next word is issued with `iss_folded`=1 and `iss_cond` set to the branch's condition. Its tag holds the branch PC, taken=0, and alt set to the branch target.
- R5: A branch is predicted taken when its condition is 4'b1110 or offset bit 23 is 1. The words queued behind it are discarded and fetching restarts at the target. The branch itself is not issued. The first word issued from the target has `iss_folded`=1 and the branch's condition, and its tag holds the branch PC, taken=1, and alt = branch PC + 4.
- R6: A branch predicted not taken whose next word is also a branch is issued itself. It has `iss_folded`=0 and its own condition, and its tag holds its own PC, taken=0, and its target as alt.
- R7: When `res_valid` and `res_mispred` are both high at a clock edge, the queue, any pending fold and any fetch in flight are discarded. `iss_valid` is then low for exactly 3 cycles, and the 4th cycle issues the non-branch word at `res_alt`.
- R8: A resolve with `res_mispred`=0 has no effect on the issued stream.
- R9: Memory data returns one cycle after a request. Requests run to consecutive word addresses, and the prefetch queue never holds more than 3 words, counting the fetch in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| imem_req | output | 1 | Fetch request |
| imem_addr | output | 32 | Fetch word address |
| imem_rdata | input | 32 | Fetched word, valid the cycle after the request |
| iss_valid | output | 1 | Issue slot holds an instruction |
| iss_instr | output | 32 | Issued instruction word |
| iss_pc | output | 32 | PC of the issued word |
| iss_cond | output | 4 | Effective condition |
| iss_folded | output | 1 | A branch was folded into this instruction |
| iss_tag_vld | output | 1 | Side tag fields are meaningful |
| iss_tag_bpc | output | 32 | PC of the predicted branch |
| iss_tag_taken | output | 1 | Predicted direction |
| iss_tag_alt | output | 32 | Address of the path not chosen |
| res_valid | input | 1 | Resolve strobe from execute |
| res_mispred | input | 1 | Prediction was wrong |
| res_alt | input | 32 | Address to restart from |

## Verification
The bench runs one program that holds all three prediction paths:
- a forward conditional branch, which a wrong design would issue or leave unfolded;
- an always-branch and a backward branch, where a design that failed to discard the queued words would let the skipped filler words leak into the stream;
- a branch followed by a branch, where a design that folded anyway would lose the second prediction.

A backward branch that loops on itself is broken by a mispredict pulse. The bench then counts the idle issue cycles exactly, since a design that flushed too little or added an extra stage would show 2 or 4 idle cycles. A resolve without a mispredict is sent in mid-stream, and a design that reacted to it would drop or repeat instructions.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
   localparam int unsigned INSTR_W     = 32;
   localparam int unsigned COND_W      = 4;
   localparam logic [3:0]  COND_ALWAYS = 4'b1110;
   localparam logic [2:0]  BR_CLASS    = 3'b101;

   function automatic logic is_branch(input logic [INSTR_W-1:0] w);
      return w[27:25] == BR_CLASS;
   endfunction

   // static rule: always-condition or negative offset means taken
   function automatic logic predict_taken(input logic [INSTR_W-1:0] w);
      return (w[31:28] == COND_ALWAYS) || w[23];
   endfunction
endpackage

// File: rtl/pfu_fetch.sv
module pfu_fetch #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DEPTH    = 3,
   parameter logic [ADDR_W-1:0] RESET_PC = '0,
   localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect,
   input  logic [ADDR_W-1:0] redir_pc,
   input  logic [CNT_W-1:0]  occ,
   output logic              req,
   output logic [ADDR_W-1:0] req_pc,
   output logic              inflight,
   output logic [ADDR_W-1:0] inflight_pc
);
   logic [ADDR_W-1:0] fpc;
   logic [CNT_W:0]    claim;

   // a word in flight already owns a queue slot
   assign claim  = {1'b0, occ} + (CNT_W+1)'(inflight);
   assign req    = rst_n && (claim < (CNT_W+1)'(DEPTH));
   assign req_pc = fpc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fpc         <= RESET_PC;
         inflight    <= 1'b0;
         inflight_pc <= '0;
      end else if (redirect) begin
         fpc      <= redir_pc;
         inflight <= 1'b0;          // returning word is dropped
      end else begin
         inflight <= req;
         if (req) begin
            inflight_pc <= fpc;
            fpc         <= fpc + ADDR_W'(4);
         end
      end
   end

   AST_REDIR_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> req && req_pc == $past(redir_pc)); // R7
endmodule

// File: rtl/pfu_buffer.sv
module pfu_buffer #(
   parameter int unsigned W      = 32,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 3,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [W-1:0]      push_w,
   input  logic [ADDR_W-1:0] push_pc,
   input  logic [1:0]        pop,
   output logic [CNT_W-1:0]  occ,
   output logic              h0_v,
   output logic [W-1:0]      h0_w,
   output logic [ADDR_W-1:0] h0_pc,
   output logic              h1_v,
   output logic [W-1:0]      h1_w,
   output logic [ADDR_W-1:0] h1_pc
);
   logic [W-1:0]      slot_w  [DEPTH];
   logic [ADDR_W-1:0] slot_pc [DEPTH];
   logic [W-1:0]      nxt_w   [DEPTH];
   logic [ADDR_W-1:0] nxt_pc  [DEPTH];
   logic [CNT_W-1:0]  occ_nxt;

   // slot i takes the entry pop positions behind it, else the pushed word
   always_comb begin
      for (int i = 0; i < int'(DEPTH); i++) begin
         nxt_w[i]  = push_w;
         nxt_pc[i] = push_pc;
         for (int j = 0; j < int'(DEPTH); j++) begin
            if (j == i + int'(pop) && j < int'(occ)) begin
               nxt_w[i]  = slot_w[j];
               nxt_pc[i] = slot_pc[j];
            end
         end
      end
      occ_nxt = flush ? '0 : occ - CNT_W'(pop) + CNT_W'(push);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ <= '0;
         for (int i = 0; i < int'(DEPTH); i++) begin
            slot_w[i]  <= '0;
            slot_pc[i] <= '0;
         end
      end else begin
         occ <= occ_nxt;
         for (int i = 0; i < int'(DEPTH); i++) begin
            slot_w[i]  <= nxt_w[i];
            slot_pc[i] <= nxt_pc[i];
         end
      end
   end

   assign h0_v  = occ >= CNT_W'(1);
   assign h1_v  = occ >= CNT_W'(2);
   assign h0_w  = slot_w[0];
   assign h0_pc = slot_pc[0];
   assign h1_w  = slot_w[1];
   assign h1_pc = slot_pc[1];

   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH)); // R9
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush) |-> (int'(occ) - int'(pop)) < int'(DEPTH)); // R9
   AST_POP_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |-> int'(pop) <= int'(occ)); // R9
endmodule

// File: rtl/pfu_fold.sv
module pfu_fold #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              h0_v,
   input  logic [31:0]       h0_w,
   input  logic [ADDR_W-1:0] h0_pc,
   input  logic              h1_v,
   input  logic [31:0]       h1_w,
   input  logic [ADDR_W-1:0] h1_pc,
   output logic [1:0]        pop,
   output logic              take,
   output logic [ADDR_W-1:0] take_pc,
   output logic              iss_valid,
   output logic [31:0]       iss_instr,
   output logic [ADDR_W-1:0] iss_pc,
   output logic [3:0]        iss_cond,
   output logic              iss_folded,
   output logic              iss_tag_vld,
   output logic [ADDR_W-1:0] iss_tag_bpc,
   output logic              iss_tag_taken,
   output logic [ADDR_W-1:0] iss_tag_alt
);
   import pfu_pkg::*;

   // pending fold left by a taken prediction, waits for the target word
   logic              pend_v, pend_tk;
   logic [3:0]        pend_cond;
   logic [ADDR_W-1:0] pend_bpc, pend_alt;

   logic              go, use_pend;
   logic [31:0]       o_instr;
   logic [ADDR_W-1:0] o_pc, o_bpc, o_alt, tgt;
   logic [3:0]        o_cond;
   logic              o_fold, o_tv, o_tk;

   assign tgt     = h0_pc + ADDR_W'(8) +
                    {{(ADDR_W-26){h0_w[23]}}, h0_w[23:0], 2'b00};
   assign take_pc = tgt;

   always_comb begin
      go = 1'b0; use_pend = 1'b0; take = 1'b0; pop = 2'd0;
      o_instr = h0_w; o_pc = h0_pc; o_cond = h0_w[31:28];
      o_fold = 1'b0; o_tv = 1'b0; o_tk = 1'b0; o_bpc = '0; o_alt = '0;
      if (h0_v && pend_v) begin
         go = 1'b1; use_pend = 1'b1; pop = 2'd1;
         o_cond = pend_cond; o_fold = 1'b1; o_tv = 1'b1;
         o_tk = pend_tk; o_bpc = pend_bpc; o_alt = pend_alt;
      end else if (h0_v && !is_branch(h0_w)) begin
         go = 1'b1; pop = 2'd1;
      end else if (h0_v && h1_v) begin
         if (predict_taken(h0_w)) begin
            take = 1'b1;
         end else if (!is_branch(h1_w)) begin
            go = 1'b1; pop = 2'd2;
            o_instr = h1_w; o_pc = h1_pc; o_fold = 1'b1; o_tv = 1'b1;
            o_bpc = h0_pc; o_alt = tgt;
         end else begin
            go = 1'b1; pop = 2'd1; o_tv = 1'b1;
            o_bpc = h0_pc; o_alt = tgt;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iss_valid <= 1'b0; iss_instr <= '0; iss_pc <= '0; iss_cond <= '0;
         iss_folded <= 1'b0; iss_tag_vld <= 1'b0; iss_tag_bpc <= '0;
         iss_tag_taken <= 1'b0; iss_tag_alt <= '0;
         pend_v <= 1'b0; pend_tk <= 1'b0; pend_cond <= '0;
         pend_bpc <= '0; pend_alt <= '0;
      end else if (flush) begin
         iss_valid <= 1'b0;
         pend_v    <= 1'b0;
      end else begin
         iss_valid <= go;
         if (go) begin
            iss_instr <= o_instr; iss_pc <= o_pc; iss_cond <= o_cond;
            iss_folded <= o_fold; iss_tag_vld <= o_tv; iss_tag_bpc <= o_bpc;
            iss_tag_taken <= o_tk; iss_tag_alt <= o_alt;
         end
         if (take) begin
            pend_v <= 1'b1; pend_tk <= 1'b1; pend_cond <= h0_w[31:28];
            pend_bpc <= h0_pc; pend_alt <= h0_pc + ADDR_W'(4);
         end else if (use_pend) begin
            pend_v <= 1'b0;
         end
      end
   end

   AST_GAP_1: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !iss_valid); // R7
   AST_GAP_2: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ##1 !iss_valid); // R7
   AST_GAP_3: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ##2 !iss_valid); // R7
   AST_PLAIN_COND: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_tag_vld) |-> (iss_cond == iss_instr[31:28] && !iss_folded)); // R2
   AST_UNFOLD_BR: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_tag_vld && !iss_folded) |-> is_branch(iss_instr)); // R6
   AST_TAKE_NOISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !flush) |=> !iss_valid); // R5
endmodule

// File: rtl/prefetch_fold_unit.sv
module prefetch_fold_unit #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 3,
   parameter logic [ADDR_W-1:0] RESET_PC = '0,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              imem_req,
   output logic [ADDR_W-1:0] imem_addr,
   input  logic [31:0]       imem_rdata,
   output logic              iss_valid,
   output logic [31:0]       iss_instr,
   output logic [ADDR_W-1:0] iss_pc,
   output logic [3:0]        iss_cond,
   output logic              iss_folded,
   output logic              iss_tag_vld,
   output logic [ADDR_W-1:0] iss_tag_bpc,
   output logic              iss_tag_taken,
   output logic [ADDR_W-1:0] iss_tag_alt,
   input  logic              res_valid,
   input  logic              res_mispred,
   input  logic [ADDR_W-1:0] res_alt
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("prefetch_fold_unit: DEPTH must be at least 2");
      end
      if (ADDR_W < 27) begin : g_bad_addr
         $error("prefetch_fold_unit: ADDR_W must be at least 27");
      end
   endgenerate

   logic              mis, take, redirect, inflight;
   logic [ADDR_W-1:0] take_pc, redir_pc, inflight_pc;
   logic [CNT_W-1:0]  occ;
   logic [1:0]        pop;
   logic              h0_v, h1_v;
   logic [31:0]       h0_w, h1_w;
   logic [ADDR_W-1:0] h0_pc, h1_pc;

   assign mis      = res_valid && res_mispred;
   assign redirect = mis || take;
   assign redir_pc = mis ? res_alt : take_pc;

   pfu_fetch #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .RESET_PC(RESET_PC)) fetch_i (
      .clk(clk), .rst_n(rst_n), .redirect(redirect), .redir_pc(redir_pc),
      .occ(occ), .req(imem_req), .req_pc(imem_addr),
      .inflight(inflight), .inflight_pc(inflight_pc));

   pfu_buffer #(.W(32), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) buf_i (
      .clk(clk), .rst_n(rst_n), .flush(redirect), .push(inflight),
      .push_w(imem_rdata), .push_pc(inflight_pc), .pop(pop), .occ(occ),
      .h0_v(h0_v), .h0_w(h0_w), .h0_pc(h0_pc),
      .h1_v(h1_v), .h1_w(h1_w), .h1_pc(h1_pc));

   pfu_fold #(.ADDR_W(ADDR_W)) fold_i (
      .clk(clk), .rst_n(rst_n), .flush(mis),
      .h0_v(h0_v), .h0_w(h0_w), .h0_pc(h0_pc),
      .h1_v(h1_v), .h1_w(h1_w), .h1_pc(h1_pc),
      .pop(pop), .take(take), .take_pc(take_pc),
      .iss_valid(iss_valid), .iss_instr(iss_instr), .iss_pc(iss_pc),
      .iss_cond(iss_cond), .iss_folded(iss_folded), .iss_tag_vld(iss_tag_vld),
      .iss_tag_bpc(iss_tag_bpc), .iss_tag_taken(iss_tag_taken),
      .iss_tag_alt(iss_tag_alt));

   AST_PRED_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !mis) |=> imem_req && imem_addr == $past(take_pc)); // R5
endmodule

// File: tb/prefetch_fold_unit_tb_top.sv
module prefetch_fold_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        imem_req;
   logic [31:0] imem_addr, imem_rdata;
   logic        iss_valid, iss_folded, iss_tag_vld, iss_tag_taken;
   logic [31:0] iss_instr, iss_pc, iss_tag_bpc, iss_tag_alt;
   logic [3:0]  iss_cond;
   logic        res_valid = 1'b0, res_mispred = 1'b0;
   logic [31:0] res_alt = '0;

   always #10 clk = ~clk;   // 50 MHz

   prefetch_fold_unit dut_i (
      .clk(clk), .rst_n(rst_n), .imem_req(imem_req), .imem_addr(imem_addr),
      .imem_rdata(imem_rdata), .iss_valid(iss_valid), .iss_instr(iss_instr),
      .iss_pc(iss_pc), .iss_cond(iss_cond), .iss_folded(iss_folded),
      .iss_tag_vld(iss_tag_vld), .iss_tag_bpc(iss_tag_bpc),
      .iss_tag_taken(iss_tag_taken), .iss_tag_alt(iss_tag_alt),
      .res_valid(res_valid), .res_mispred(res_mispred), .res_alt(res_alt));

   logic [31:0] mem [64];
   always @(posedge clk) if (imem_req) imem_rdata <= mem[imem_addr[7:2]];

   typedef struct {
      logic [31:0] ins, pc, bpc, alt;
      logic [3:0]  cond;
      logic        fold, tv, tk;
      string       req;
   } exp_t;
   exp_t q[$];
   int total = 0, bad = 0, seen = 0;

   function automatic logic [31:0] alu(input logic [3:0] c, input int k, input logic [2:0] cls);
      return {c, cls, 5'd0, 20'(k)};
   endfunction
   function automatic logic [31:0] br(input logic [3:0] c, input int off);
      return {c, 3'b101, 1'b0, 24'(off)};
   endfunction

   task automatic push_exp(input logic [31:0] ins, pc, input logic [3:0] cond,
                           input logic fold, tv, tk, input logic [31:0] bpc, alt,
                           input string req);
      exp_t e;
      e.ins = ins; e.pc = pc; e.cond = cond; e.fold = fold; e.tv = tv;
      e.tk = tk; e.bpc = bpc; e.alt = alt; e.req = req;
      q.push_back(e);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever an instruction is issued
   always @(negedge clk) begin
      if (rst_n && iss_valid && q.size() > 0) begin
         exp_t e;
         bit ok;
         e = q.pop_front();
         seen++;
         ok = iss_instr == e.ins && iss_pc == e.pc && iss_cond == e.cond &&
              iss_folded == e.fold && iss_tag_vld == e.tv &&
              (!e.tv || (iss_tag_bpc == e.bpc && iss_tag_taken == e.tk &&
                         iss_tag_alt == e.alt));
         total++;
         if (!ok) begin
            bad++;
            $display("FAIL %s pc actual=%h expected=%h instr actual=%h expected=%h cond %h/%h fold %b/%b tag %b %h %b %h / %b %h %b %h",
                     e.req, iss_pc, e.pc, iss_instr, e.ins, iss_cond, e.cond,
                     iss_folded, e.fold, iss_tag_vld, iss_tag_bpc, iss_tag_taken,
                     iss_tag_alt, e.tv, e.bpc, e.tk, e.alt);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      mem[0]  = alu(4'hE, 1, 3'b000);
      mem[1]  = alu(4'hE, 2, 3'b000);
      mem[2]  = br(4'h0, 2);              // 0x08 -> 0x18, forward
      mem[3]  = alu(4'hE, 3, 3'b000);
      mem[4]  = alu(4'hE, 4, 3'b100);     // R3: 27:25=100 is not a branch
      mem[5]  = br(4'hE, 3);              // 0x14 -> 0x28, always
      for (int i = 6; i < 10; i++) mem[i] = alu(4'hE, 'h990 + i, 3'b000);
      mem[10] = alu(4'hE, 10, 3'b000);    // 0x28
      mem[11] = alu(4'hE, 11, 3'b000);    // 0x2C
      mem[12] = br(4'h1, -3);             // 0x30 -> 0x2C, backward
      mem[13] = alu(4'hE, 13, 3'b000);    // 0x34
      mem[14] = br(4'h2, 1);              // 0x38 -> 0x44
      mem[15] = br(4'h3, 0);              // 0x3C -> 0x44
      mem[16] = alu(4'hE, 16, 3'b000);    // 0x40
      mem[17] = alu(4'hE, 17, 3'b000);    // 0x44

      push_exp(mem[0],  32'h00, 4'hE, 0, 0, 0, 0, 0, "R2 plain word 0");
      push_exp(mem[1],  32'h04, 4'hE, 0, 0, 0, 0, 0, "R2 plain word 1");
      push_exp(mem[3],  32'h0C, 4'h0, 1, 1, 0, 32'h08, 32'h18, "R4 forward fold");
      push_exp(mem[4],  32'h10, 4'hE, 0, 0, 0, 0, 0, "R3/R8 non-branch class after resolve");
      push_exp(mem[10], 32'h28, 4'hE, 1, 1, 1, 32'h14, 32'h18, "R5 always-taken fold");
      push_exp(mem[11], 32'h2C, 4'hE, 0, 0, 0, 0, 0, "R2 plain after fold");
      push_exp(mem[11], 32'h2C, 4'h1, 1, 1, 1, 32'h30, 32'h34, "R5 backward taken fold");

      repeat (3) @(negedge clk);
      chk(!iss_valid, "R1 idle in reset", {31'd0, iss_valid}, 0);
      rst_n = 1'b1;
      #1;
      chk(imem_req && imem_addr == 32'h0, "R1 first fetch", imem_addr, 32'h0);
      @(negedge clk); #1;
      chk(imem_req && imem_addr == 32'h4, "R9 sequential fetch", imem_addr, 32'h4);
      @(negedge clk); #1;
      chk(imem_req && imem_addr == 32'h8, "R9 sequential fetch", imem_addr, 32'h8);

      while (seen < 3) @(negedge clk);
      #1; res_valid = 1'b1; res_mispred = 1'b0; res_alt = 32'h18;   // R8
      @(negedge clk); #1; res_valid = 1'b0;

      forever begin
         @(negedge clk); #1;
         if (iss_valid && iss_pc == 32'h2C && iss_folded) break;
      end
      push_exp(mem[13], 32'h34, 4'hE, 0, 0, 0, 0, 0, "R7 first word after mispredict");
      push_exp(mem[14], 32'h38, 4'h2, 0, 1, 0, 32'h38, 32'h44, "R6 branch before branch");
      push_exp(mem[16], 32'h40, 4'h3, 1, 1, 0, 32'h3C, 32'h44, "R4 zero-offset forward fold");
      push_exp(mem[17], 32'h44, 4'hE, 0, 0, 0, 0, 0, "R2 plain at end");
      res_valid = 1'b1; res_mispred = 1'b1; res_alt = 32'h34;
      @(negedge clk); #1;
      res_valid = 1'b0; res_mispred = 1'b0;
      chk(!iss_valid, "R7 gap cycle 1", {31'd0, iss_valid}, 0);
      @(negedge clk); #1;
      chk(!iss_valid, "R7 gap cycle 2", {31'd0, iss_valid}, 0);
      @(negedge clk); #1;
      chk(!iss_valid, "R7 gap cycle 3", {31'd0, iss_valid}, 0);
      @(negedge clk); #1;
      chk(iss_valid && iss_pc == 32'h34, "R7 restart at alt", iss_pc, 32'h34);

      for (int n = 0; n < 50 && q.size() > 0; n++) @(negedge clk);
      chk(q.size() == 0, "R6 all expected items issued", q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule